// File: doc/BRIEF.md
# SD Video Word Pairing Repacker

This block sits on the receive side of a multi-standard serial video path. It takes a standard-definition stream and gives downstream logic a 20-bit word, which is the width that HD and 3G streams already use. In SD operation only the low 10 bits of the incoming bus carry video. Those bits hold chroma and luma samples interleaved as Cb, Y, Cr, Y. A strobe marks each valid sample, and in the ideal case it arrives five and six clocks apart in turn.

The block joins each chroma sample to the luma sample that follows it. It emits one word with luma in the upper half and chroma in the lower half. The output strobe has an exact period of eleven clocks, so a consumer sees one regular word rate. A sync pulse at the first Cb after a timing reference re-anchors the chroma/luma phase, so the pairing cannot drift by one sample.

A bypass input sends the full 20-bit bus and its strobe through unchanged for HD and 3G streams. Bypass has the same single register of latency as the SD path.

Top module: `sd_word_repacker`

## Requirements
- R1: While reset is asserted and after its release, `dout_vld` is 0 and `dout` is all zeros until the first output event.
- R2: With `bypass_en` high, `dout` and `dout_vld` equal `din` and `din_vld` of the previous clock cycle.
- R3: With `bypass_en` low, `din[19:10]` has no effect on any output.
- R4: In SD mode, the first valid sample after reset, mode entry or sync is chroma, and the next one is luma. The word for a pair has luma at `dout[19:10]` and chroma at `dout[9:0]`.
- R5: The first pair after SD mode entry is presented with `dout_vld` high in the clock cycle right after the cycle that carried its luma sample.
- R6: After the first SD output, `dout_vld` can only be high in slots spaced exactly 11 cycles apart. Under the ideal 5/6-cycle input spacing, every slot carries a word, which gives one cycle high and ten cycles low.
- R7: A pair completed between slots is held and presented at the next slot. A slot with no new pair since the previous output gives no pulse.
- R8: A `sync_cb` pulse discards any held chroma. If it comes together with `din_vld`, that sample is taken as Cb. If it comes alone, the next valid sample is taken as chroma.
- R9: In SD mode, no output is produced until both a chroma and a luma sample have been received.
- R10: Leaving SD mode for bypass and returning drops any half-captured pair and restarts the output cadence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock shared by input and output |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_en | input | 1 | 1: pass the 20-bit bus through (HD/3G); 0: SD repacking |
| sync_cb | input | 1 | Marks the first Cb after a timing reference |
| din | input | 20 | Input data; SD uses only bits [9:0] |
| din_vld | input | 1 | Input sample strobe |
| dout | output | 20 | Output word; in SD, luma [19:10] and chroma [9:0] |
| dout_vld | output | 1 | Output word strobe |

## Verification
Some properties are checked on every cycle. The bypass pipeline is checked for exact one-cycle delay of data and strobe. Any two SD output pulses must be at least eleven cycles apart. An SD output may only appear after at least two valid samples since SD mode entry, and reset must leave the output quiet. Other behaviours depend on the order in which samples and sync pulses arrive, so only the bench scenarios can show them: the chroma/luma pairing and its placement in the word, the hold-until-slot behaviour, sync re-anchoring, and the ignored upper input bits.

// File: rtl/sd_repack_pkg.sv
package sd_repack_pkg;
    localparam int SD_SAMPLE_W = 10;
    localparam int SD_SLOT_PERIOD = 11;

    typedef enum logic {
        PH_CHROMA = 1'b0,
        PH_LUMA   = 1'b1
    } sample_phase_e;
endpackage

// File: rtl/sd_pair_capture.sv
module sd_pair_capture
    import sd_repack_pkg::*;
#(
    parameter int SAMPLE_W = SD_SAMPLE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  sync,
    input  logic                  vld,
    input  logic [SAMPLE_W-1:0]   sample,
    output logic                  pair_done,
    output logic [2*SAMPLE_W-1:0] pair_word
);
    typedef struct packed {
        sample_phase_e         phase;
        logic [SAMPLE_W-1:0]   chroma;
    } cap_t;

    cap_t cur_q, cur_d;

    always_comb begin
        cur_d     = cur_q;
        pair_done = 1'b0;
        if (clear) begin
            cur_d.phase = PH_CHROMA;
        end else if (sync) begin
            // re-anchor: a coincident sample is the Cb, otherwise wait for it
            if (vld) begin
                cur_d.chroma = sample;
                cur_d.phase  = PH_LUMA;
            end else begin
                cur_d.phase  = PH_CHROMA;
            end
        end else if (vld) begin
            if (cur_q.phase == PH_CHROMA) begin
                cur_d.chroma = sample;
                cur_d.phase  = PH_LUMA;
            end else begin
                pair_done    = 1'b1;
                cur_d.phase  = PH_CHROMA;
            end
        end
        pair_word = {sample, cur_q.chroma};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{phase: PH_CHROMA, chroma: '0};
        end else begin
            cur_q <= cur_d;
        end
    end
endmodule

// File: rtl/sd_slot_timer.sv
module sd_slot_timer
    import sd_repack_pkg::*;
#(
    parameter int PERIOD = SD_SLOT_PERIOD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic running,
    output logic slot
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (clear) begin
            t_d.run = 1'b0;
            t_d.cnt = '0;
        end else if (!t_q.run) begin
            if (start) begin
                t_d.run = 1'b1;
                t_d.cnt = CW'(1);
            end
        end else if (t_q.cnt == CW'(PERIOD - 1)) begin
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + CW'(1);
        end
        running = t_q.run;
        slot    = t_q.run && (t_q.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{run: 1'b0, cnt: '0};
        end else begin
            t_q <= t_d;
        end
    end
endmodule

// File: rtl/sd_word_repacker.sv
module sd_word_repacker
    import sd_repack_pkg::*;
#(
    parameter int SAMPLE_W = SD_SAMPLE_W,
    parameter int PERIOD   = SD_SLOT_PERIOD
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bypass_en,
    input  logic                  sync_cb,
    input  logic [2*SAMPLE_W-1:0] din,
    input  logic                  din_vld,
    output logic [2*SAMPLE_W-1:0] dout,
    output logic                  dout_vld
);
    localparam int WORD_W = 2 * SAMPLE_W;

    typedef struct packed {
        logic [WORD_W-1:0] held;
        logic              pending;
        logic [WORD_W-1:0] word;
        logic              vld;
    } out_t;

    out_t o_q, o_d;

    logic              pair_done;
    logic [WORD_W-1:0] pair_word;
    logic              tmr_running;
    logic              tmr_slot;
    logic              first_pair;
    logic              emit;

    sd_pair_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (bypass_en),
        .sync      (sync_cb),
        .vld       (din_vld),
        .sample    (din[SAMPLE_W-1:0]),
        .pair_done (pair_done),
        .pair_word (pair_word)
    );

    sd_slot_timer #(.PERIOD(PERIOD)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (bypass_en),
        .start   (first_pair),
        .running (tmr_running),
        .slot    (tmr_slot)
    );

    always_comb begin
        o_d        = o_q;
        first_pair = !bypass_en && !tmr_running && pair_done;
        emit       = first_pair || (!bypass_en && tmr_slot && (pair_done || o_q.pending));
        if (bypass_en) begin
            o_d.word    = din;
            o_d.vld     = din_vld;
            o_d.pending = 1'b0;
        end else begin
            o_d.vld = emit;
            if (emit) begin
                o_d.word    = pair_done ? pair_word : o_q.held;
                o_d.pending = 1'b0;
            end else if (pair_done) begin
                // off-slot pair waits for the next slot
                o_d.held    = pair_word;
                o_d.pending = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '{held: '0, pending: 1'b0, word: '0, vld: 1'b0};
        end else begin
            o_q <= o_d;
        end
    end

    assign dout     = o_q.word;
    assign dout_vld = o_q.vld;
endmodule

// File: rtl/sd_word_repacker_chk.sv
module sd_word_repacker_chk #(
    parameter int SAMPLE_W = 10,
    parameter int PERIOD   = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bypass_en,
    input logic [2*SAMPLE_W-1:0] din,
    input logic                  din_vld,
    input logic [2*SAMPLE_W-1:0] dout,
    input logic                  dout_vld
);
    localparam int GW = $clog2(PERIOD + 1);

    logic          prev_byp_q;
    logic          seen_q;
    logic [GW-1:0] gap_q;
    logic [1:0]    vcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_byp_q <= 1'b1;
            seen_q     <= 1'b0;
            gap_q      <= '0;
            vcnt_q     <= '0;
        end else begin
            prev_byp_q <= bypass_en;
            if (bypass_en) begin
                vcnt_q <= '0;
            end else if (din_vld && vcnt_q != 2'd2) begin
                vcnt_q <= vcnt_q + 2'd1;
            end
            if (bypass_en) begin
                seen_q <= 1'b0;
                gap_q  <= '0;
            end else if (dout_vld && !prev_byp_q) begin
                seen_q <= 1'b1;
                gap_q  <= '0;
            end else if (gap_q != GW'(PERIOD)) begin
                gap_q  <= gap_q + GW'(1);
            end
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!dout_vld && dout == '0));

    p_bypass_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_en |=> (dout_vld == $past(din_vld) && dout == $past(din)));

    p_slot_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_vld && !prev_byp_q && seen_q) |-> (gap_q >= GW'(PERIOD - 1)));

    p_pair_before_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_vld && !prev_byp_q) |-> (vcnt_q == 2'd2));
endmodule

bind sd_word_repacker sd_word_repacker_chk #(
    .SAMPLE_W (SAMPLE_W),
    .PERIOD   (PERIOD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bypass_en (bypass_en),
    .din       (din),
    .din_vld   (din_vld),
    .dout      (dout),
    .dout_vld  (dout_vld)
);

// File: tb/sd_word_repacker_test.sv
module sd_word_repacker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bypass_en = 1'b0;
    logic        sync_cb = 1'b0;
    logic [19:0] din = '0;
    logic        din_vld = 1'b0;
    logic [19:0] dout;
    logic        dout_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sd_word_repacker uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bypass_en (bypass_en),
        .sync_cb   (sync_cb),
        .din       (din),
        .din_vld   (din_vld),
        .dout      (dout),
        .dout_vld  (dout_vld)
    );

    // each row: {upper junk[29:20], chroma[19:10], luma[9:0]}
    localparam logic [29:0] VEC [6] = '{
        {10'h3FF, 10'h200, 10'h040},
        {10'h155, 10'h1F0, 10'h3AC},
        {10'h2AA, 10'h001, 10'h3FE},
        {10'h000, 10'h3FF, 10'h000},
        {10'h0F0, 10'h123, 10'h234},
        {10'h30C, 10'h155, 10'h2AA}
    };

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic byp, input logic syn, input logic v, input logic [19:0] d);
        @(negedge clk);
        bypass_en = byp;
        sync_cb   = syn;
        din_vld   = v;
        din       = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b0, 1'b0, 20'hFFFFF);
            check(req, {19'd0, dout_vld}, 20'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 vld in reset", {19'd0, dout_vld}, 20'd0);
        check("R1 data in reset", dout, 20'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1 quiet after reset");
        check("R1 data after reset", dout, 20'd0);

        // R2 bypass pipeline
        step(1'b1, 1'b0, 1'b1, 20'hABCDE);
        check("R2 bypass vld", {19'd0, dout_vld}, 20'd1);
        check("R2 bypass data", dout, 20'hABCDE);
        step(1'b1, 1'b0, 1'b0, 20'h12345);
        check("R2 bypass vld low", {19'd0, dout_vld}, 20'd0);
        check("R2 bypass data", dout, 20'h12345);

        // table walk: ideal cadence, junk upper bits (R3, R4, R5, R6)
        for (int r = 0; r < 6; r++) begin
            logic [9:0] junk, cr, lu;
            junk = VEC[r][29:20];
            cr   = VEC[r][19:10];
            lu   = VEC[r][9:0];
            step(1'b0, 1'b0, 1'b1, {junk, cr});
            check("R9 no out on chroma", {19'd0, dout_vld}, 20'd0);
            idle(4, "R6 low between slots");
            step(1'b0, 1'b0, 1'b1, {~junk, lu});
            check("R5 R6 vld on pair", {19'd0, dout_vld}, 20'd1);
            check("R3 R4 pair word", dout, {lu, cr});
            idle(5, "R6 low between slots");
        end

        // R7 off-slot pair held to next slot, then an empty slot
        step(1'b0, 1'b0, 1'b1, 20'h00111);
        check("R7 off-slot chroma", {19'd0, dout_vld}, 20'd0);
        idle(1, "R7 wait");
        step(1'b0, 1'b0, 1'b1, 20'h00222);
        check("R7 no out off slot", {19'd0, dout_vld}, 20'd0);
        idle(2, "R7 hold until slot");
        step(1'b0, 1'b0, 1'b0, 20'h0);
        check("R7 slot vld", {19'd0, dout_vld}, 20'd1);
        check("R7 held word", dout, {10'h222, 10'h111});
        idle(11, "R7 empty slot gives no pulse");

        // R8 sync together with a sample
        step(1'b1, 1'b0, 1'b0, 20'h0);
        step(1'b0, 1'b0, 1'b1, 20'h000AA);
        step(1'b0, 1'b1, 1'b1, 20'h000BB);
        check("R8 sync sample no out", {19'd0, dout_vld}, 20'd0);
        step(1'b0, 1'b0, 1'b1, 20'h000CC);
        check("R8 sync vld", {19'd0, dout_vld}, 20'd1);
        check("R8 sync pairs new Cb", dout, {10'h0CC, 10'h0BB});

        // R8 sync alone re-anchors phase
        step(1'b1, 1'b0, 1'b0, 20'h0);
        step(1'b0, 1'b0, 1'b1, 20'h00011);
        step(1'b0, 1'b1, 1'b0, 20'h0);
        step(1'b0, 1'b0, 1'b1, 20'h00022);
        check("R8 lone sync no out", {19'd0, dout_vld}, 20'd0);
        step(1'b0, 1'b0, 1'b1, 20'h00033);
        check("R8 lone sync vld", {19'd0, dout_vld}, 20'd1);
        check("R8 lone sync word", dout, {10'h033, 10'h022});

        // R10 mode switch drops half pair
        step(1'b0, 1'b0, 1'b1, 20'h00044);
        step(1'b1, 1'b0, 1'b0, 20'h0);
        step(1'b0, 1'b0, 1'b1, 20'h00055);
        check("R10 restart chroma", {19'd0, dout_vld}, 20'd0);
        step(1'b0, 1'b0, 1'b1, 20'h00066);
        check("R10 restart vld", {19'd0, dout_vld}, 20'd1);
        check("R10 restart word", dout, {10'h066, 10'h055});

        // R9 lone chroma never produces output
        step(1'b1, 1'b0, 1'b0, 20'h0);
        step(1'b0, 1'b0, 1'b1, 20'h00077);
        check("R9 lone chroma", {19'd0, dout_vld}, 20'd0);
        idle(3, "R9 no out without luma");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule